// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is a circular word buffer placed between a host register port and a card-side data engine. The transfer direction decides which side fills the buffer and which side drains it. In receive direction the engine pushes and the host pops. In transmit direction the host pushes and the engine pops. Storage is kept as a head index plus an occupancy count, and every index wraps modulo the depth.

The block compares its own fill level against two programmable thresholds. When a threshold is crossed, it raises either a DMA request line or a level flag in the status register, depending on the direction and on a per-direction DMA enable. The status register also holds sticky event bits that other logic sets. Software clears those bits by writing ones. A 15-bit enable mask gates the status bits onto a single interrupt line.

The threshold evaluation is registered. Request lines and level flags therefore follow the occupancy one clock later. A configuration write takes effect on the same edge at which it is written.

Top module: `tfifo_dmareq`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x1F00, which means almost-full level 31, almost-empty level 0 and both DMA enables off. After reset, `stat_rdata` reads 0, and `irq`, `rx_dma_req` and `tx_dma_req` are all low.
- R2: Words leave the buffer in the order they entered, and storage indices wrap modulo 32. In transmit direction (`dir_rx`=0) the host pushes and the engine pops. In receive direction (`dir_rx`=1) the engine pushes and the host pops.
- R3: A push while 32 words are held is discarded, and the stored contents and the count stay unchanged.
- R4: A pop while the buffer is empty removes nothing. The read data then shows the word at the head index, and a later push and pop return the newly pushed word.
- R5: In receive direction, with a transfer active or data held, an occupancy above the almost-full level (`cfg_wdata[12:8]`) with receive DMA enabled (`cfg_wdata[15]`) raises `rx_dma_req` and keeps status bit 10 clear.
- R6: Under the same receive condition with receive DMA disabled, status bit 10 is set and `rx_dma_req` stays low. At or below the level, both are low.
- R7: In transmit direction, an occupancy below the almost-empty level (`cfg_wdata[4:0]`) raises `tx_dma_req` when transmit DMA is enabled (`cfg_wdata[7]`), or sets status bit 11 when it is disabled. At or above the level, both are low.
- R8: With `xfer_active` low and the buffer empty, status bits 10 and 11 and both request lines are low.
- R9: A configuration write that sets a DMA enable clears the matching level bit at the same edge as the write.
- R10: A push or pop on the port that the current direction does not use has no effect.
- R11: `stat_evt[i]` sets sticky status bit i, for every bit except 10 and 11. Writing a one to `stat_clr_data[i]` clears it. `irq` is high exactly when some status bit among 14:0 is set together with its `mask_wdata` bit, so bit 15 never raises `irq`.
- R12: Request lines and level bits reflect the occupancy one clock after the occupancy changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rx | input | 1 | 1 = receive (engine fills), 0 = transmit (host fills) |
| xfer_active | input | 1 | A data transfer is in progress |
| host_wr_en | input | 1 | Host push strobe |
| host_wr_data | input | 16 | Host push word |
| host_rd_en | input | 1 | Host pop strobe |
| host_rd_data | output | 16 | Word at the head index |
| eng_wr_en | input | 1 | Engine push strobe |
| eng_wr_data | input | 16 | Engine push word |
| eng_rd_en | input | 1 | Engine pop strobe |
| eng_rd_data | output | 16 | Word at the head index |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration read-back |
| stat_evt | input | 16 | Sticky status set pulses |
| stat_clr_we | input | 1 | Status write-one-to-clear strobe |
| stat_clr_data | input | 16 | Status bits to clear |
| stat_rdata | output | 16 | Status register |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 15 | Interrupt mask value |
| irq | output | 1 | Masked interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The buffer is first driven in transmit direction with a short batch and then a full batch that starts mid-array. The full batch separates correct wrap-around from an index that saturates, and the push made while full shows whether a full push overwrites the head slot. Receive-direction traffic exercises the swapped port roles, along with strobes on the unused ports that must leave the contents intact. The thresholds are probed at exactly the level and one word past it, with DMA on and off, which tells a strict comparison from an inclusive one and a request from a flag.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
   // register layout of the configuration word
   localparam int CFG_LVL_W      = 5;
   localparam int CFG_RX_DMA_BIT = 15;
   localparam int CFG_AF_LSB     = 8;
   localparam int CFG_TX_DMA_BIT = 7;
   localparam int CFG_AE_LSB     = 0;
   // level flag positions in the status word
   localparam int STAT_RX_LVL    = 10;
   localparam int STAT_TX_LVL    = 11;

   typedef struct packed {
      logic                 rx_dma;
      logic [CFG_LVL_W-1:0] af_lvl;
      logic                 tx_dma;
      logic [CFG_LVL_W-1:0] ae_lvl;
   } lvl_cfg_t;

   function automatic lvl_cfg_t cfg_unpack(input logic [15:0] w);
      lvl_cfg_t c;
      c.rx_dma = w[CFG_RX_DMA_BIT];
      c.af_lvl = w[CFG_AF_LSB +: CFG_LVL_W];
      c.tx_dma = w[CFG_TX_DMA_BIT];
      c.ae_lvl = w[CFG_AE_LSB +: CFG_LVL_W];
      return c;
   endfunction

   function automatic logic [15:0] cfg_pack(input lvl_cfg_t c);
      logic [15:0] w;
      w = '0;
      w[CFG_RX_DMA_BIT]            = c.rx_dma;
      w[CFG_AF_LSB +: CFG_LVL_W]   = c.af_lvl;
      w[CFG_TX_DMA_BIT]            = c.tx_dma;
      w[CFG_AE_LSB +: CFG_LVL_W]   = c.ae_lvl;
      return w;
   endfunction
endpackage

// File: rtl/tfd_store.sv
module tfd_store #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head_data,
   output logic [AW-1:0]    head,
   output logic [CW-1:0]    count,
   output logic             empty
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    head_q;
   logic [CW-1:0]    cnt_q;
   logic [AW-1:0]    tail_idx;
   logic             do_push;
   logic             do_pop;

   assign do_push  = push && (cnt_q != FULL_CNT);
   assign do_pop   = pop && (cnt_q != '0);
   // power-of-two depth: dropping the carry gives the modulo wrap
   assign tail_idx = head_q + cnt_q[AW-1:0];

   always_ff @(posedge clk) begin
      if (do_push) mem_q[tail_idx] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_pop) head_q <= head_q + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head_data = mem_q[head_q];
   assign head      = head_q;
   assign count     = cnt_q;
   assign empty     = (cnt_q == '0);
endmodule

// File: rtl/tfd_level.sv
module tfd_level
   import tfd_pkg::*;
#(
   parameter int CW        = 6,
   parameter bit REGISTERED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic          active,
   input  logic          dir_rx,
   input  lvl_cfg_t      cfg,
   output logic          rx_req,
   output logic          tx_req,
   output logic          rx_flag,
   output logic          tx_flag
);
   logic rx_hit, tx_hit;
   logic [3:0] nxt;

   assign rx_hit = active && dir_rx  && (32'(count) > 32'(cfg.af_lvl));
   assign tx_hit = active && !dir_rx && (32'(count) < 32'(cfg.ae_lvl));

   assign nxt = {rx_hit &&  cfg.rx_dma,
                 rx_hit && !cfg.rx_dma,
                 tx_hit &&  cfg.tx_dma,
                 tx_hit && !cfg.tx_dma};

   generate
      if (REGISTERED) begin : g_reg
         logic [3:0] lvl_q;
         always_ff @(posedge clk) begin
            if (!rst_n) lvl_q <= '0;
            else        lvl_q <= nxt;
         end
         assign {rx_req, rx_flag, tx_req, tx_flag} = lvl_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign {rx_req, rx_flag, tx_req, tx_flag} = nxt;
      end
   endgenerate
endmodule

// File: rtl/tfd_status.sv
module tfd_status #(
   parameter int STATW  = 16,
   parameter int MASKW  = 15,
   parameter int RX_BIT = 10,
   parameter int TX_BIT = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [STATW-1:0] evt,
   input  logic             clr_we,
   input  logic [STATW-1:0] clr_data,
   input  logic             mask_we,
   input  logic [MASKW-1:0] mask_data,
   input  logic             rx_flag,
   input  logic             tx_flag,
   output logic [STATW-1:0] status,
   output logic [MASKW-1:0] mask,
   output logic             irq
);
   logic [MASKW-1:0] mask_q;
   logic             unused_lvl_bits;

   assign unused_lvl_bits = ^{evt[RX_BIT], evt[TX_BIT], clr_data[RX_BIT], clr_data[TX_BIT]};

   for (genvar i = 0; i < STATW; i++) begin : g_bit
      if (i == RX_BIT) begin : g_rx
         assign status[i] = rx_flag;
      end else if (i == TX_BIT) begin : g_tx
         assign status[i] = tx_flag;
      end else begin : g_sticky
         logic sticky_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                    sticky_q <= 1'b0;
            else if (evt[i])               sticky_q <= 1'b1;
            else if (clr_we && clr_data[i]) sticky_q <= 1'b0;
         end
         assign status[i] = sticky_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_data;
   end

   assign mask = mask_q;
   assign irq  = |(status[MASKW-1:0] & mask_q);
endmodule

// File: rtl/tfifo_dmareq.sv
module tfifo_dmareq
   import tfd_pkg::*;
#(
   parameter int WIDTH          = 16,
   parameter int DEPTH          = 32,
   parameter bit LEVEL_REGISTER = 1'b1,
   localparam int AW            = $clog2(DEPTH),
   localparam int CW            = AW + 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        dir_rx,
   input  logic        xfer_active,
   input  logic        host_wr_en,
   input  logic [WIDTH-1:0] host_wr_data,
   input  logic        host_rd_en,
   output logic [WIDTH-1:0] host_rd_data,
   input  logic        eng_wr_en,
   input  logic [WIDTH-1:0] eng_wr_data,
   input  logic        eng_rd_en,
   output logic [WIDTH-1:0] eng_rd_data,
   input  logic        cfg_we,
   input  logic [15:0] cfg_wdata,
   output logic [15:0] cfg_rdata,
   input  logic [15:0] stat_evt,
   input  logic        stat_clr_we,
   input  logic [15:0] stat_clr_data,
   output logic [15:0] stat_rdata,
   input  logic        mask_we,
   input  logic [14:0] mask_wdata,
   output logic        irq,
   output logic        rx_dma_req,
   output logic        tx_dma_req
);
   localparam lvl_cfg_t CFG_RST = '{rx_dma: 1'b0, af_lvl: 5'h1F, tx_dma: 1'b0, ae_lvl: 5'h00};

   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2 || DEPTH > 32) begin : g_bad_depth
         $error("tfifo_dmareq: DEPTH must be a power of two from 2 to 32");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tfifo_dmareq: WIDTH must be positive");
      end
   endgenerate

   lvl_cfg_t         cfg_q, cfg_eff;
   logic             push_req, pop_req;
   logic [WIDTH-1:0] push_word, head_word;
   logic [AW-1:0]    head_ptr;
   logic [CW-1:0]    fill_cnt;
   logic             fifo_empty;
   logic             rx_flag, tx_flag;
   logic [14:0]      mask_q;

   // the direction picks which side fills and which side drains
   assign push_req  = dir_rx ? eng_wr_en   : host_wr_en;
   assign push_word = dir_rx ? eng_wr_data : host_wr_data;
   assign pop_req   = dir_rx ? host_rd_en  : eng_rd_en;

   always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q <= CFG_RST;
      else if (cfg_we) cfg_q <= cfg_unpack(cfg_wdata);
   end

   // a write is seen by the evaluator on its own edge
   assign cfg_eff   = cfg_we ? cfg_unpack(cfg_wdata) : cfg_q;
   assign cfg_rdata = cfg_pack(cfg_q);

   tfd_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_req),
      .push_data (push_word),
      .pop       (pop_req),
      .head_data (head_word),
      .head      (head_ptr),
      .count     (fill_cnt),
      .empty     (fifo_empty)
   );

   assign host_rd_data = head_word;
   assign eng_rd_data  = head_word;

   tfd_level #(.CW(CW), .REGISTERED(LEVEL_REGISTER)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .count   (fill_cnt),
      .active  (xfer_active || !fifo_empty),
      .dir_rx  (dir_rx),
      .cfg     (cfg_eff),
      .rx_req  (rx_dma_req),
      .tx_req  (tx_dma_req),
      .rx_flag (rx_flag),
      .tx_flag (tx_flag)
   );

   tfd_status #(.STATW(16), .MASKW(15), .RX_BIT(STAT_RX_LVL), .TX_BIT(STAT_TX_LVL)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (stat_evt),
      .clr_we    (stat_clr_we),
      .clr_data  (stat_clr_data),
      .mask_we   (mask_we),
      .mask_data (mask_wdata),
      .rx_flag   (rx_flag),
      .tx_flag   (tx_flag),
      .status    (stat_rdata),
      .mask      (mask_q),
      .irq       (irq)
   );
endmodule

// File: rtl/tfd_chk.sv
module tfd_chk
   import tfd_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          xfer_active,
   input logic          cfg_we,
   input logic [15:0]   cfg_wdata,
   input logic [15:0]   stat_rdata,
   input logic [14:0]   mask_q,
   input logic          irq,
   input logic          rx_dma_req,
   input logic          tx_dma_req,
   input logic          push_req,
   input logic          pop_req,
   input logic [AW-1:0] head_ptr,
   input logic [CW-1:0] fill_cnt
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_cnt == FULL_CNT && push_req && !pop_req) |=> (fill_cnt == FULL_CNT));

   a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_cnt == '0 && pop_req && !push_req) |=> (fill_cnt == '0 && $stable(head_ptr)));

   a_r5_rx_req_or_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_dma_req && stat_rdata[STAT_RX_LVL]));

   a_r7_tx_req_or_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_dma_req && stat_rdata[STAT_TX_LVL]));

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_active && fill_cnt == '0) |=>
         (!rx_dma_req && !tx_dma_req && !stat_rdata[STAT_RX_LVL] && !stat_rdata[STAT_TX_LVL]));

   a_r9_rx_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[CFG_RX_DMA_BIT]) |=> !stat_rdata[STAT_RX_LVL]);

   a_r9_tx_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[CFG_TX_DMA_BIT]) |=> !stat_rdata[STAT_TX_LVL]);

   a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_dma_req && tx_dma_req));

   a_r11_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);
endmodule

bind tfifo_dmareq tfd_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .xfer_active (xfer_active),
   .cfg_we      (cfg_we),
   .cfg_wdata   (cfg_wdata),
   .stat_rdata  (stat_rdata),
   .mask_q      (mask_q),
   .irq         (irq),
   .rx_dma_req  (rx_dma_req),
   .tx_dma_req  (tx_dma_req),
   .push_req    (push_req),
   .pop_req     (pop_req),
   .head_ptr    (head_ptr),
   .fill_cnt    (fill_cnt)
);

// File: tb/tfifo_dmareq_test.sv
`timescale 1ns/1ps
module tfifo_dmareq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dir_rx = 1'b0, xfer_active = 1'b0;
   logic        host_wr_en = 1'b0, host_rd_en = 1'b0, eng_wr_en = 1'b0, eng_rd_en = 1'b0;
   logic [15:0] host_wr_data = '0, eng_wr_data = '0;
   logic [15:0] host_rd_data, eng_rd_data;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0, cfg_rdata;
   logic [15:0] stat_evt = '0, stat_clr_data = '0, stat_rdata;
   logic        stat_clr_we = 1'b0, mask_we = 1'b0;
   logic [14:0] mask_wdata = '0;
   logic        irq, rx_dma_req, tx_dma_req;

   int checks = 0;
   int errors = 0;
   logic [15:0] sb [$];

   always #2.5 clk = ~clk;

   tfifo_dmareq uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic host_push(input logic [15:0] w);
      host_wr_data = w; host_wr_en = 1'b1;
      if (!dir_rx && sb.size() < 32) sb.push_back(w);
      tick(); host_wr_en = 1'b0;
   endtask

   task automatic eng_push(input logic [15:0] w);
      eng_wr_data = w; eng_wr_en = 1'b1;
      if (dir_rx && sb.size() < 32) sb.push_back(w);
      tick(); eng_wr_en = 1'b0;
   endtask

   task automatic host_pop();
      host_rd_en = 1'b1; tick(); host_rd_en = 1'b0;
   endtask

   task automatic eng_pop();
      eng_rd_en = 1'b1; tick(); eng_rd_en = 1'b0;
   endtask

   task automatic cfg_write(input logic [15:0] v);
      cfg_wdata = v; cfg_we = 1'b1; tick(); cfg_we = 1'b0;
   endtask

   task automatic mask_write(input logic [14:0] v);
      mask_wdata = v; mask_we = 1'b1; tick(); mask_we = 1'b0;
   endtask

   task automatic stat_clear(input logic [15:0] v);
      stat_clr_data = v; stat_clr_we = 1'b1; tick(); stat_clr_we = 1'b0;
   endtask

   // monitor: the draining side is compared with the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (!dir_rx && eng_rd_en && sb.size() > 0) chk("R2 transmit order", eng_rd_data, sb.pop_front());
         if (dir_rx && host_rd_en && sb.size() > 0) chk("R2 receive order", host_rd_data, sb.pop_front());
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 cfg", cfg_rdata, 16'h1F00);
      chk("R1 status", stat_rdata, 16'h0000);
      chk("R1 requests", {irq, rx_dma_req, tx_dma_req}, 3'b000);

      // R2 transmit traffic, then a full batch starting at index 20
      xfer_active = 1'b1;
      for (int i = 0; i < 20; i++) host_push(16'h1000 + 16'(i));
      for (int i = 0; i < 20; i++) eng_pop();
      for (int i = 0; i < 32; i++) host_push(16'h2000 + 16'(i));
      host_push(16'hDEAD);                       // R3 push while full
      chk("R3 head kept", eng_rd_data, 16'h2000);
      for (int i = 0; i < 32; i++) eng_pop();
      chk("R2 queue drained", sb.size(), 0);
      // R4 empty pop
      chk("R4 head word", eng_rd_data, 16'h2000);
      eng_pop();
      chk("R4 head unmoved", eng_rd_data, 16'h2000);
      host_push(16'h5A5A);
      chk("R4 new word", eng_rd_data, 16'h5A5A);
      eng_pop();

      // R7 transmit threshold with DMA, then as a flag
      cfg_write(16'h1F84);
      chk("R7 dma request", {tx_dma_req, stat_rdata[11]}, 2'b10);
      cfg_write(16'h1F04);
      chk("R7 flag", {tx_dma_req, stat_rdata[11]}, 2'b01);
      mask_write(15'h0800);
      chk("R11 irq from level", irq, 1'b1);
      for (int i = 0; i < 4; i++) host_push(16'h3000 + 16'(i));
      chk("R12 lag", stat_rdata[11], 1'b1);
      tick();
      chk("R7 at level", {tx_dma_req, stat_rdata[11]}, 2'b00);
      for (int i = 0; i < 4; i++) eng_pop();
      tick();
      chk("R7 below again", stat_rdata[11], 1'b1);
      // R8 idle and empty
      xfer_active = 1'b0;
      tick(); tick();
      chk("R8 idle", {rx_dma_req, tx_dma_req, stat_rdata[11], stat_rdata[10]}, 4'b0000);
      xfer_active = 1'b1;
      tick();
      chk("R8 active again", stat_rdata[11], 1'b1);
      // R9 enabling DMA clears the flag on the write edge
      cfg_write(16'h1F84);
      chk("R9 tx clear", {tx_dma_req, stat_rdata[11]}, 2'b10);
      cfg_write(16'h1F00);
      mask_write(15'h0000);

      // receive direction: R5 and R6
      dir_rx = 1'b1;
      cfg_write(16'h0300);
      for (int i = 0; i < 3; i++) eng_push(16'h4000 + 16'(i));
      tick();
      chk("R6 at level", {rx_dma_req, stat_rdata[10]}, 2'b00);
      eng_push(16'h4003);
      tick();
      chk("R6 flag above", {rx_dma_req, stat_rdata[10]}, 2'b01);
      cfg_write(16'h8300);
      chk("R5 request", {rx_dma_req, stat_rdata[10]}, 2'b10);
      for (int i = 0; i < 4; i++) host_pop();
      tick();
      chk("R6 below", {rx_dma_req, stat_rdata[10]}, 2'b00);
      cfg_write(16'h1F00);

      // R10 unused-side strobes
      host_push(16'hBEEF);
      eng_push(16'h1111);
      eng_push(16'h2222);
      eng_pop();
      chk("R10 head after ignored strobes", host_rd_data, 16'h1111);
      host_pop();
      host_pop();
      chk("R10 queue drained", sb.size(), 0);

      // R11 sticky status and mask
      xfer_active = 1'b0;
      dir_rx = 1'b0;
      tick();
      stat_evt = 16'h0001; tick(); stat_evt = '0;
      chk("R11 sticky set", stat_rdata, 16'h0001);
      chk("R11 masked off", irq, 1'b0);
      mask_write(15'h0001);
      chk("R11 irq on", irq, 1'b1);
      stat_clear(16'h0001);
      chk("R11 cleared", {stat_rdata, irq}, {16'h0000, 1'b0});
      mask_write(15'h7FFF);
      stat_evt = 16'h8000; tick(); stat_evt = '0;
      chk("R11 bit15 no irq", {stat_rdata, irq}, {16'h8000, 1'b0});
      stat_clear(16'h8000);
      chk("R11 bit15 cleared", stat_rdata, 16'h0000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule